// File: doc/BRIEF.md
# Serial Clock Rate Generator with Bus-Idle Detection

This block drives the clock line of a two-wire bus master. A programmable 8-bit rate value is loaded into an up-counter that steps once per system clock. When the counter would wrap past its maximum, the clock drive flips and the counter reloads from the rate value. Each half-period therefore lasts 256 minus the rate value cycles. The drive is registered and models an open-drain pin, where 1 means the line is released.

While the drive is released, the counter waits until the synchronized line actually reads high. A slave that holds the line low thus lengthens the high phase without shortening it. The two-flop input synchronizer adds two cycles to every high phase.

A second counter watches the synchronized clock and data lines. When both have stayed high for ten times (257 minus the rate value) cycles, it raises a bus-idle flag. The flag clears as soon as either line is seen low. Byte transfer, start and stop generation, and data shifting belong to other blocks.

Top module: `smb_scl_gen`

## Requirements
- R1: After reset, the rate value is 0x00, `scl_drv_o` is 1 (released) and `bus_free_o` is 0.
- R2: While enabled, every low phase of `scl_drv_o` lasts exactly 256 − P cycles, where P is the rate value at the reload that began the phase.
- R3: While enabled and with no slave holding the line, every high phase of `scl_drv_o` lasts exactly 258 − P cycles.
- R4: Suppose a slave holds `scl_in` low after the drive is released, and lets go on cycle H counted from the rising edge of the drive. The high phase then lasts H + 258 − P cycles, and the drive never falls while the synchronized line reads low.
- R5: A rate write lands on the next clock edge and is used only at the next reload. A phase already running keeps the length set by the old value.
- R6: While `gen_en` is 0, `scl_drv_o` is 1 from the next edge on and never toggles. After `gen_en` rises with the line high, the drive falls 256 − P clock edges later.
- R7: With both lines high, `bus_free_o` first reads 1 exactly 10 × (257 − P) + 2 clock edges after the later of the two lines rose at the pins.
- R8: On the third clock edge after either `scl_in` or `sda_in` goes low, `bus_free_o` reads 0. It stays 0 until the idle count completes again.
- R9: At the extreme rate value 0xFF, the low phase lasts 1 cycle and the high phase lasts 3 cycles. The stale synchronizer value from the previous high phase must not cut the high phase short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_we | input | 1 | Write strobe for the rate value |
| rate_wdata | input | 8 | New rate value |
| gen_en | input | 1 | Clock generation enable |
| scl_in | input | 1 | Sampled level of the clock line |
| sda_in | input | 1 | Sampled level of the data line |
| scl_drv_o | output | 1 | Clock drive, 1 = released, 0 = pull low |
| bus_free_o | output | 1 | Bus-idle flag |

## Verification
The bench uses the default parameters: an 8-bit rate value, an idle multiplier of ten and two synchronizer stages. With these, rate values near 0xFF give half-periods of only a few cycles, so many phases fit into a short run. At 0xFF the one-cycle low phase puts the stale synchronizer value right at the start of the next high phase. Rate value 0x00 gives the longest idle timeout, 2572 edges, which stays well within the run length.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    localparam int unsigned SCL_RATE_W_DEF  = 8;
    localparam int unsigned SCL_IDLE_MUL    = 10;
    localparam int unsigned SCL_SYNC_N_DEF  = 2;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout_o = sh_q[STAGES-1];
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_rate_pkg::*;
#(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              line_hi_i,
    output logic              drv_o
);
    typedef struct packed {
        logic [RATE_W-1:0] tmr;
        scl_phase_e        ph;
        logic              low_seen;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    step;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (!en_i) begin
            st_d.tmr      = rate_i;
            st_d.ph       = PH_HIGH;
            st_d.low_seen = 1'b1;
        end else begin
            // a low reading proves the line saw this low phase
            if (!line_hi_i) st_d.low_seen = 1'b1;
            step = (st_q.ph == PH_LOW) || (line_hi_i && st_q.low_seen);
            if (step) begin
                if (st_q.tmr == {RATE_W{1'b1}}) begin
                    st_d.tmr = rate_i;
                    if (st_q.ph == PH_HIGH) begin
                        st_d.ph       = PH_LOW;
                        st_d.low_seen = 1'b0;
                    end else begin
                        st_d.ph = PH_HIGH;
                    end
                end else begin
                    st_d.tmr = st_q.tmr + RATE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tmr      <= '0;
            st_q.ph       <= PH_HIGH;
            st_q.low_seen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_o = (st_q.ph == PH_HIGH);
endmodule

// File: rtl/scl_idle_timer.sv
module scl_idle_timer #(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned MUL    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_hi_i,
    input  logic              sda_hi_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              idle_o
);
    localparam int unsigned SPAN = (1 << RATE_W) + 1;
    localparam int unsigned CW   = $clog2(MUL * SPAN + 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } idle_st_t;

    idle_st_t      st_d, st_q;
    logic [CW-1:0] lim;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        lim     = CW'(MUL * (SPAN - int'(rate_i)));
        cnt_inc = st_q.cnt + CW'(1);
        st_d    = st_q;
        if (scl_hi_i && sda_hi_i) begin
            st_d.cnt  = (st_q.cnt >= lim) ? st_q.cnt : cnt_inc;
            st_d.flag = (cnt_inc >= lim);
        end else begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_o = st_q.flag;
endmodule

// File: rtl/smb_scl_gen.sv
module smb_scl_gen
    import scl_rate_pkg::*;
#(
    parameter int unsigned RATE_W  = SCL_RATE_W_DEF,
    parameter int unsigned IDLE_MUL = SCL_IDLE_MUL,
    parameter int unsigned SYNC_N  = SCL_SYNC_N_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              gen_en,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drv_o,
    output logic              bus_free_o
);
    localparam int unsigned N_LINES = 2;

    logic [RATE_W-1:0]  rate_d, rate_q;
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               scl_s;
    logic               sda_s;

    always_comb begin
        rate_d = rate_we ? rate_wdata : rate_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rate_q <= '0;
        else        rate_q <= rate_d;
    end

    assign raw_lines = {sda_in, scl_in};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_sync
        scl_line_sync #(.STAGES(SYNC_N)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din_i (raw_lines[gi]),
            .dout_o(sync_lines[gi])
        );
    end

    assign scl_s = sync_lines[0];
    assign sda_s = sync_lines[1];

    scl_phase_timer #(.RATE_W(RATE_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (gen_en),
        .rate_i   (rate_q),
        .line_hi_i(scl_s),
        .drv_o    (scl_drv_o)
    );

    scl_idle_timer #(.RATE_W(RATE_W), .MUL(IDLE_MUL)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_hi_i(scl_s),
        .sda_hi_i(sda_s),
        .rate_i  (rate_q),
        .idle_o  (bus_free_o)
    );
endmodule

// File: rtl/smb_scl_gen_chk.sv
module smb_scl_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic scl_drv_o,
    input logic bus_free_o,
    input logic scl_s,
    input logic sda_s
);
    // R6: disabled generator releases the line on the next edge
    assert_release_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> scl_drv_o);

    // R4: a line seen low keeps the drive released
    assert_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drv_o && !scl_s) |=> scl_drv_o);

    // R8: any low line clears the idle flag on the next edge
    assert_idle_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_s || !sda_s) |=> !bus_free_o);

    // R7: the idle flag only follows a cycle with both lines high
    assert_idle_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free_o |-> ($past(scl_s) && $past(sda_s)));
endmodule

bind smb_scl_gen smb_scl_gen_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .scl_drv_o (scl_drv_o),
    .bus_free_o(bus_free_o),
    .scl_s     (scl_s),
    .sda_s     (sda_s)
);

// File: tb/smb_scl_gen_tb_top.sv
module smb_scl_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wdata = 8'h00;
    logic       gen_en = 1'b0;
    logic       sda_in = 1'b1;
    logic       slave_hold = 1'b0;
    logic       scl_line;
    logic       scl_drv;
    logic       bus_free;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign scl_line = scl_drv & ~slave_hold;

    smb_scl_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_we   (rate_we),
        .rate_wdata(rate_wdata),
        .gen_en    (gen_en),
        .scl_in    (scl_line),
        .sda_in    (sda_in),
        .scl_drv_o (scl_drv),
        .bus_free_o(bus_free)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // behavioural reference, compared on every falling edge
    int m_rate, m_tmr, m_drv, m_seen, m_s1, m_s2, m_d1, m_d2, m_cnt, m_bf;
    always @(negedge clk) begin
        int both, lim, n_tmr, n_drv, n_seen, n_cnt, n_bf;
        if (!rst_n) begin
            m_rate = 0; m_tmr = 0; m_drv = 1; m_seen = 1;
            m_s1 = 0; m_s2 = 0; m_d1 = 0; m_d2 = 0; m_cnt = 0; m_bf = 0;
        end else begin
            checks++;
            if (scl_drv !== m_drv[0] || bus_free !== m_bf[0]) begin
                errors++;
                $display("FAIL R2/R3/R7 model actual=%0d%0d expected=%0d%0d",
                         scl_drv, bus_free, m_drv, m_bf);
            end
            both = m_s2 & m_d2;
            lim  = 10 * (257 - m_rate);
            n_cnt = both ? ((m_cnt >= lim) ? m_cnt : m_cnt + 1) : 0;
            n_bf  = (both && (m_cnt + 1 >= lim)) ? 1 : 0;
            n_tmr = m_tmr; n_drv = m_drv; n_seen = m_seen;
            if (!gen_en) begin
                n_tmr = m_rate; n_drv = 1; n_seen = 1;
            end else begin
                if (!m_s2) n_seen = 1;
                if (m_drv == 0 || (m_s2 && m_seen)) begin
                    if (m_tmr == 255) begin
                        n_tmr = m_rate;
                        if (m_drv == 1) begin n_drv = 0; n_seen = 0; end
                        else n_drv = 1;
                    end else n_tmr = m_tmr + 1;
                end
            end
            m_s2 = m_s1; m_s1 = scl_line;
            m_d2 = m_d1; m_d1 = sda_in;
            m_tmr = n_tmr; m_drv = n_drv; m_seen = n_seen;
            m_cnt = n_cnt; m_bf = n_bf;
            if (rate_we) m_rate = rate_wdata;
        end
    end

    // run-length tracker of the clock drive
    int run = 0, last_low = 0, last_high = 0, rise_cnt = 0, fall_cnt = 0;
    logic prev_drv = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_drv == prev_drv) run++;
            else begin
                if (prev_drv) begin last_high = run; fall_cnt++; end
                else begin last_low = run; rise_cnt++; end
                run = 1;
                prev_drv = scl_drv;
            end
        end
    end

    task automatic wait_fall();
        int f0 = fall_cnt;
        wait (fall_cnt != f0);
    endtask

    task automatic wait_rise();
        int r0 = rise_cnt;
        wait (rise_cnt != r0);
    endtask

    task automatic write_rate(input int v);
        @(posedge clk); #1;
        rate_we = 1'b1; rate_wdata = 8'(v);
        @(posedge clk); #1;
        rate_we = 1'b0;
    endtask

    task automatic check_period(input int p, input string tag);
        wait_fall(); wait_fall();
        wait_rise();
        chk({tag, " low R2"}, last_low, 256 - p);
        wait_fall();
        chk({tag, " high R3"}, last_high, 258 - p);
    endtask

    task automatic idle_after_release(input int p, input string tag);
        int k = 0;
        repeat (4) @(posedge clk);
        #1 sda_in = 1'b0;
        repeat (5) @(posedge clk);
        #1 sda_in = 1'b1;
        do begin
            @(posedge clk); k++;
            @(negedge clk);
        end while (!bus_free && k < 3000);
        chk({tag, " R7 idle edges"}, k, 10 * (257 - p) + 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 drive released", int'(scl_drv), 1);
        chk("R1 idle flag", int'(bus_free), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: rate starts at 0x00, so the idle timeout is 2572 edges
        idle_after_release(0, "rate 0x00 R1");

        write_rate(8'hF0);
        @(posedge clk); #1 gen_en = 1'b1;
        check_period(8'hF0, "p=F0");
        check_period(8'hF0, "p=F0 again");

        write_rate(8'h80);
        check_period(8'h80, "p=80");

        // R9 boundary
        write_rate(8'hFF);
        check_period(8'hFF, "p=FF R9");
        check_period(8'hFF, "p=FF R9 again");

        // R5: write lands mid low phase
        write_rate(8'hF0);
        wait_fall(); wait_fall();
        @(posedge clk); #1 rate_we = 1'b1; rate_wdata = 8'hE0;
        @(posedge clk); #1 rate_we = 1'b0;
        wait_rise();
        chk("R5 current low kept", last_low, 16);
        wait_fall();
        chk("R5 next high uses new", last_high, 258 - 8'hE0);
        wait_rise();
        chk("R5 next low uses new", last_low, 256 - 8'hE0);

        // R4: slave holds the line for 20 cycles after release
        write_rate(8'hF0);
        wait_fall(); wait_fall();
        @(posedge clk); #1 slave_hold = 1'b1;
        wait_rise();
        repeat (20) @(posedge clk);
        #1 slave_hold = 1'b0;
        wait_fall();
        chk("R4 stretched high", last_high, 20 + 258 - 8'hF0);

        // R6: disable, then re-enable with a new rate
        @(posedge clk); #1 gen_en = 1'b0;
        begin
            int bad = 0;
            @(posedge clk);
            repeat (100) begin
                @(negedge clk);
                if (!scl_drv) bad++;
            end
            chk("R6 no toggle while off", bad, 0);
        end
        write_rate(8'hF8);
        repeat (4) @(posedge clk);
        @(posedge clk); #1 gen_en = 1'b1;
        begin
            int k = 0;
            do begin
                @(posedge clk); k++;
                @(negedge clk);
            end while (scl_drv && k < 1000);
            chk("R6 first fall after enable", k, 256 - 8'hF8);
        end

        // idle detection with generator off
        @(posedge clk); #1 gen_en = 1'b0;
        write_rate(8'hF0);
        idle_after_release(8'hF0, "p=F0");
        @(posedge clk); #1 sda_in = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8 flag after 1 edge", int'(bus_free), 1);
        @(posedge clk); @(negedge clk);
        chk("R8 flag after 2 edges", int'(bus_free), 1);
        @(posedge clk); @(negedge clk);
        chk("R8 flag after 3 edges", int'(bus_free), 0);
        @(posedge clk); #1 sda_in = 1'b1;

        write_rate(8'hFF);
        idle_after_release(8'hFF, "p=FF");
        // R8 via the clock line held low by a slave
        @(posedge clk); #1 slave_hold = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 scl low flag kept 2 edges", int'(bus_free), 1);
        @(posedge clk); @(negedge clk);
        chk("R8 scl low flag cleared", int'(bus_free), 0);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R8 flag stays low while held", int'(bus_free), 0);
        @(posedge clk); #1 slave_hold = 1'b0;
        repeat (10) @(posedge clk);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule